// File: doc/BRIEF.md
# Floating-Point Status and Control Register Unit

This block holds the 32-bit floating-point status/control word of a processor core and carries out the six instructions that move it or change it. An instruction is presented as a 32-bit word together with a 64-bit floating-point source operand and a one-cycle valid strobe. On the clock edge of the strobe the block decodes the word and does one of the following: it sets or clears a single status bit, rewrites any chosen subset of the eight 4-bit status fields from the operand, or writes a 4-bit immediate into one field. It can also copy one status field into a field of the 32-bit condition register, which clears the sticky exception bits held in that field. Finally, it can return the whole status word as a 64-bit value.

The unit has no multi-cycle states. Its control is a decoded operation kind, chosen once per strobe: `OP_NONE` (no strobe), `OP_BSET`, `OP_BCLR`, `OP_MASKW` (masked field write), `OP_IMMW` (immediate field write), `OP_COPY` (field copy to the condition register), `OP_READ` and `OP_BAD` (illegal word). Every kind moves straight from the strobe edge to its register update. The unit then returns to waiting, and nothing is carried into the next cycle apart from the registers. Two things are left to other logic: the summary bits for exception and enabled exception, and the result-class bits.

Top module: `fp_status_ctl`

## Requirements
- R1: While `rst_n` is low, `status`, `cr` and `rd_val` are zero and `illegal` is low.
- R2: Every update happens on the rising clock edge at which `valid` is high and is visible from that edge on. Without `valid`, no output changes and `illegal` stays low.
- R3: A word is legal only if bits 31..26 equal 63 and bits 10..1 hold one of these extended codes: 38 (bit set), 70 (bit clear), 711 (masked field write), 134 (immediate field write), 64 (field copy), 583 (read). Any other word is illegal.
- R4: Bit set and bit clear act on status bit (31 - n), where n is taken from instruction bits 25..21. Bits 20..16 and bits 15..11 must be zero, or the word is illegal.
- R5: The masked field write takes an 8-bit mask from bits 24..17. Where mask bit k is 1, status bits 4k+3..4k are replaced by the same bits of `src`. Bits 63..32 of `src` are ignored. The word is illegal if bit 25 or bit 16 is 1.
- R6: The immediate field write takes a field number f from bits 25..23 and a 4-bit value from bits 15..12, and writes the value to status bits (31-4f)..(28-4f). The word is illegal if any of bits 22..16 or bit 11 is 1.
- R7: The field copy takes a destination d from bits 25..21 and a source s from bits 20..16. Both must be multiples of 4, and bits 15..11 must be zero. CR field d/4 receives status field s/4, with field 0 at bits 31..28 of each register.
- R8: Each field copy clears exception bits of the source field in the status register, using the status value from before the copy. Source field 0 clears bits 31 and 28; field 1 clears bits 27..24; field 2 clears bits 23..20; field 3 clears bit 19; field 5 clears bit 8. Fields 4, 6 and 7 clear nothing.
- R9: The read is legal only when bits 20..11 are zero. It sets `rd_val` to {32'hFFF80000, status}. `rd_val` holds its value at every other time.
- R10: A read always clears CR bits 27..25. Bit set, bit clear, masked write and immediate write clear CR bits 27..25 when instruction bit 0 is 1. CR bit 24 is never cleared this way, and the field copy ignores bit 0.
- R11: An illegal word pulses `illegal` high for the one cycle after its strobe edge and changes neither `status`, `cr` nor `rd_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid | input | 1 | Instruction strobe, one edge per instruction |
| instr | input | 32 | Instruction word |
| src | input | 64 | Floating-point source operand |
| status | output | 32 | Status/control register |
| cr | output | 32 | Condition register |
| rd_val | output | 64 | Value returned by the last read |
| illegal | output | 1 | High for one cycle after an illegal word |

## Verification
Every result of this unit is registered, so `status`, `cr`, `rd_val` and `illegal` are due exactly one clock edge after the edge that samples `valid`. No result is due earlier, and none is due later. The bench drives each word at a falling edge and samples on the next falling edge, which is half a cycle after the update. One scenario also samples before the update edge to show that nothing moves early. The illegal pulse is checked on that same falling edge, and again one idle cycle later, to confirm that it lasts a single cycle.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;

    localparam int REG_W   = 32;
    localparam int FLD_W   = 4;
    localparam int NFIELD  = REG_W / FLD_W;
    localparam int OPD_W   = 2 * REG_W;

    localparam logic [5:0] OPC_FP   = 6'd63;
    localparam logic [9:0] XO_BSET  = 10'd38;
    localparam logic [9:0] XO_BCLR  = 10'd70;
    localparam logic [9:0] XO_MASKW = 10'd711;
    localparam logic [9:0] XO_IMMW  = 10'd134;
    localparam logic [9:0] XO_COPY  = 10'd64;
    localparam logic [9:0] XO_READ  = 10'd583;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_BSET,
        OP_BCLR,
        OP_MASKW,
        OP_IMMW,
        OP_COPY,
        OP_READ,
        OP_BAD
    } fpsc_op_e;

    // Sticky exception bits cleared inside a source field by a field copy
    function automatic logic [FLD_W-1:0] copy_clear_bits(input logic [2:0] fld);
        logic [FLD_W-1:0] r;
        unique case (fld)
            3'd0:    r = 4'b1001;
            3'd1:    r = 4'b1111;
            3'd2:    r = 4'b1111;
            3'd3:    r = 4'b1000;
            3'd5:    r = 4'b0001;
            default: r = 4'b0000;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fpsc_decode.sv
module fpsc_decode
    import fpsc_pkg::*;
(
    input  logic        valid,
    input  logic [31:0] instr,
    output fpsc_op_e    op,
    output logic        rec,
    output logic [4:0]  fld_a,
    output logic [4:0]  fld_b,
    output logic [7:0]  fmask,
    output logic [3:0]  imm,
    output logic [2:0]  ifield
);

    logic [5:0] opc;
    logic [9:0] xo;
    logic [4:0] fld_c;

    assign opc    = instr[31:26];
    assign xo     = instr[10:1];
    assign fld_a  = instr[25:21];
    assign fld_b  = instr[20:16];
    assign fld_c  = instr[15:11];
    assign fmask  = instr[24:17];
    assign imm    = instr[15:12];
    assign ifield = instr[25:23];
    assign rec    = instr[0];

    always_comb begin
        op = OP_NONE;
        if (valid) begin
            if (opc != OPC_FP) begin
                op = OP_BAD;
            end else begin
                unique case (xo)
                    XO_BSET:  op = (fld_b == 5'd0 && fld_c == 5'd0) ? OP_BSET : OP_BAD;
                    XO_BCLR:  op = (fld_b == 5'd0 && fld_c == 5'd0) ? OP_BCLR : OP_BAD;
                    XO_MASKW: op = (!instr[25] && !instr[16]) ? OP_MASKW : OP_BAD;
                    XO_IMMW:  op = (instr[22:16] == 7'd0 && !instr[11]) ? OP_IMMW : OP_BAD;
                    XO_COPY:  op = (fld_a[1:0] == 2'd0 && fld_b[1:0] == 2'd0 && fld_c == 5'd0)
                                   ? OP_COPY : OP_BAD;
                    XO_READ:  op = (fld_b == 5'd0 && fld_c == 5'd0) ? OP_READ : OP_BAD;
                    default:  op = OP_BAD;
                endcase
            end
        end
    end

endmodule

// File: rtl/fpsc_status_next.sv
module fpsc_status_next
    import fpsc_pkg::*;
(
    input  logic [REG_W-1:0] cur,
    input  fpsc_op_e         op,
    input  logic [4:0]       fld_a,
    input  logic [4:0]       fld_b,
    input  logic [7:0]       fmask,
    input  logic [3:0]       imm,
    input  logic [2:0]       ifield,
    input  logic [REG_W-1:0] src_lo,
    output logic [REG_W-1:0] nxt
);

    logic [NFIELD-1:0] nib_en;
    logic [REG_W-1:0]  nib_mask;
    logic [REG_W-1:0]  bit_mask;
    logic [REG_W-1:0]  wdata;
    logic [REG_W-1:0]  wmask;
    logic [2:0]        src_nib;

    assign src_nib = 3'd7 - fld_b[4:2];

    always_comb begin
        nib_en   = '0;
        bit_mask = '0;
        wdata    = '0;
        unique case (op)
            OP_BSET: begin
                bit_mask = 32'd1 << (5'd31 - fld_a);
                wdata    = '1;
            end
            OP_BCLR: begin
                bit_mask = 32'd1 << (5'd31 - fld_a);
            end
            OP_MASKW: begin
                nib_en = fmask;
                wdata  = src_lo;
            end
            OP_IMMW: begin
                nib_en = 8'd1 << (3'd7 - ifield);
                wdata  = {NFIELD{imm}};
            end
            OP_COPY: begin
                bit_mask = {28'd0, copy_clear_bits(fld_b[4:2])} << {src_nib, 2'b00};
            end
            default: begin
                nib_en = '0;
            end
        endcase
    end

    for (genvar k = 0; k < NFIELD; k++) begin : g_nib
        assign nib_mask[k*FLD_W +: FLD_W] = {FLD_W{nib_en[k]}};
    end

    assign wmask = nib_mask | bit_mask;
    assign nxt   = (cur & ~wmask) | (wdata & wmask);

endmodule

// File: rtl/fp_status_ctl.sv
module fp_status_ctl
    import fpsc_pkg::*;
#(
    parameter logic [31:0] READ_HI = 32'hFFF80000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid,
    input  logic [31:0] instr,
    input  logic [63:0] src,
    output logic [31:0] status,
    output logic [31:0] cr,
    output logic [63:0] rd_val,
    output logic        illegal
);

    fpsc_op_e         op;
    logic             rec;
    logic [4:0]       fld_a;
    logic [4:0]       fld_b;
    logic [7:0]       fmask;
    logic [3:0]       imm;
    logic [2:0]       ifield;
    logic [REG_W-1:0] status_q, status_d;
    logic [REG_W-1:0] cr_q, cr_d, cr_copy;
    logic [OPD_W-1:0] rd_q, rd_d;
    logic             illegal_q;
    logic [2:0]       src_nib;
    logic [2:0]       dst_nib;
    logic [FLD_W-1:0] copy_val;
    logic             cr1_clear;
    logic             unused_src_hi;

    assign unused_src_hi = ^src[OPD_W-1:REG_W];

    fpsc_decode i_decode (
        .valid  (valid),
        .instr  (instr),
        .op     (op),
        .rec    (rec),
        .fld_a  (fld_a),
        .fld_b  (fld_b),
        .fmask  (fmask),
        .imm    (imm),
        .ifield (ifield)
    );

    fpsc_status_next i_status_next (
        .cur    (status_q),
        .op     (op),
        .fld_a  (fld_a),
        .fld_b  (fld_b),
        .fmask  (fmask),
        .imm    (imm),
        .ifield (ifield),
        .src_lo (src[REG_W-1:0]),
        .nxt    (status_d)
    );

    assign src_nib  = 3'd7 - fld_b[4:2];
    assign dst_nib  = 3'd7 - fld_a[4:2];
    assign copy_val = status_q[{src_nib, 2'b00} +: FLD_W];

    for (genvar k = 0; k < NFIELD; k++) begin : g_cr
        assign cr_copy[k*FLD_W +: FLD_W] =
            (op == OP_COPY && dst_nib == 3'(k)) ? copy_val : cr_q[k*FLD_W +: FLD_W];
    end

    // Output-side next values
    always_comb begin
        unique case (op)
            OP_READ:                            cr1_clear = 1'b1;
            OP_BSET, OP_BCLR, OP_MASKW, OP_IMMW: cr1_clear = rec;
            default:                            cr1_clear = 1'b0;
        endcase
        cr_d = cr_copy;
        if (cr1_clear) begin
            cr_d[27:25] = 3'b000;
        end
        rd_d = (op == OP_READ) ? {READ_HI, status_q} : rd_q;
    end

    // Register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q  <= '0;
            cr_q      <= '0;
            rd_q      <= '0;
            illegal_q <= 1'b0;
        end else begin
            status_q  <= status_d;
            cr_q      <= cr_d;
            rd_q      <= rd_d;
            illegal_q <= (op == OP_BAD);
        end
    end

    assign status  = status_q;
    assign cr      = cr_q;
    assign rd_val  = rd_q;
    assign illegal = illegal_q;

endmodule

// File: rtl/fp_status_ctl_chk.sv
module fp_status_ctl_chk #(
    parameter logic [31:0] READ_HI = 32'hFFF80000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        valid,
    input logic [31:0] status,
    input logic [31:0] cr,
    input logic [63:0] rd_val,
    input logic        illegal
);

    // R11
    illegal_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> ($stable(status) && $stable(cr) && $stable(rd_val)));

    // R2
    idle_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(valid) |-> ($stable(status) && $stable(cr) && $stable(rd_val) && !illegal));

    // R9
    read_high_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_val) |-> (rd_val[63:32] == READ_HI));

    // R10
    read_clears_cr1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_val) |-> (cr[27:25] == 3'b000));

    // R9
    read_low_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_val) |-> (rd_val[31:0] == status));

endmodule

bind fp_status_ctl fp_status_ctl_chk #(.READ_HI(READ_HI)) i_fp_status_ctl_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (valid),
    .status  (status),
    .cr      (cr),
    .rd_val  (rd_val),
    .illegal (illegal)
);

// File: tb/test_fp_status_ctl.sv
module test_fp_status_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] src = '0;
    logic [31:0] status;
    logic [31:0] cr;
    logic [63:0] rd_val;
    logic        illegal;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    fp_status_ctl i_fp_status_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (valid),
        .instr   (instr),
        .src     (src),
        .status  (status),
        .cr      (cr),
        .rd_val  (rd_val),
        .illegal (illegal)
    );

    function automatic logic [31:0] w_x(input int xo, input logic [4:0] a,
                                        input logic [4:0] b, input logic [4:0] c,
                                        input logic rc);
        logic [9:0] x = 10'(xo);
        return {6'd63, a, b, c, x, rc};
    endfunction

    function automatic logic [31:0] w_mask(input logic [7:0] m, input logic rc);
        return {6'd63, 1'b0, m, 1'b0, 5'd0, 10'd711, rc};
    endfunction

    function automatic logic [31:0] w_imm(input logic [2:0] f, input logic [3:0] v,
                                          input logic rc);
        return {6'd63, f, 7'd0, v, 1'b0, 10'd134, rc};
    endfunction

    function automatic logic [31:0] w_copy(input logic [2:0] d, input logic [2:0] s,
                                           input logic rc);
        return w_x(64, {d, 2'b00}, {s, 2'b00}, 5'd0, rc);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w, input logic [63:0] opnd, input logic v);
        @(negedge clk);
        instr = w;
        src   = opnd;
        valid = v;
        @(negedge clk);
        valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 status", status, 0);
        check("R1 cr", cr, 0);
        check("R1 rd_val", rd_val, 0);
        check("R1 illegal", illegal, 0);
    endtask

    task automatic t_bitops;
        issue(w_x(38, 5'd0, 5'd0, 5'd0, 1'b0), 64'd0, 1'b1);
        check("R4 set bit 31", status, 32'h8000_0000);
        issue(w_x(38, 5'd31, 5'd0, 5'd0, 1'b0), 64'd0, 1'b1);
        check("R4 set bit 0", status, 32'h8000_0001);
        issue(w_x(70, 5'd0, 5'd0, 5'd0, 1'b0), 64'd0, 1'b1);
        check("R4 clear bit 31", status, 32'h0000_0001);
        check("R4 cr untouched", cr, 0);
    endtask

    task automatic t_masked;
        issue(w_mask(8'h81, 1'b0), 64'hDEAD_BEEF_1234_5678, 1'b1);
        check("R5 mask 0x81", status, 32'h1000_0008);
        issue(w_mask(8'h00, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        check("R5 empty mask", status, 32'h1000_0008);
    endtask

    task automatic t_imm;
        issue(w_imm(3'd2, 4'hA, 1'b0), 64'd0, 1'b1);
        check("R6 field 2", status, 32'h10A0_0008);
        issue(w_imm(3'd0, 4'h0, 1'b0), 64'd0, 1'b1);
        check("R6 field 0", status, 32'h00A0_0008);
    endtask

    task automatic t_read;
        issue(w_x(583, 5'd3, 5'd0, 5'd0, 1'b0), 64'd0, 1'b1);
        check("R9 read value", rd_val, 64'hFFF8_0000_00A0_0008);
        check("R9 status kept", status, 32'h00A0_0008);
    endtask

    task automatic t_copy;
        issue(w_mask(8'hFF, 1'b0), 64'h0000_0000_FFFF_FFFF, 1'b1);
        check("R5 full mask", status, 32'hFFFF_FFFF);
        issue(w_copy(3'd1, 3'd0, 1'b0), 64'd0, 1'b1);
        check("R7 copy f0->c1", cr, 32'h0F00_0000);
        check("R8 clear f0", status, 32'h6FFF_FFFF);
        issue(w_copy(3'd7, 3'd1, 1'b0), 64'd0, 1'b1);
        check("R7 copy f1->c7", cr, 32'h0F00_000F);
        check("R8 clear f1", status, 32'h60FF_FFFF);
        issue(w_copy(3'd2, 3'd3, 1'b0), 64'd0, 1'b1);
        check("R7 copy f3->c2", cr, 32'h0FF0_000F);
        check("R8 clear f3", status, 32'h60F7_FFFF);
        issue(w_copy(3'd0, 3'd5, 1'b0), 64'd0, 1'b1);
        check("R7 copy f5->c0", cr, 32'hFFF0_000F);
        check("R8 clear f5", status, 32'h60F7_FEFF);
        issue(w_copy(3'd3, 3'd4, 1'b0), 64'd0, 1'b1);
        check("R7 copy f4->c3", cr, 32'hFFFF_000F);
        check("R8 f4 clears none", status, 32'h60F7_FEFF);
    endtask

    task automatic t_record;
        issue(w_x(583, 5'd3, 5'd0, 5'd0, 1'b0), 64'd0, 1'b1);
        check("R9 read after copies", rd_val, 64'hFFF8_0000_60F7_FEFF);
        check("R10 read clears cr1", cr, 32'hF1FF_000F);
        issue(w_copy(3'd1, 3'd0, 1'b0), 64'd0, 1'b1);
        check("R7 refill cr1", cr, 32'hF6FF_000F);
        issue(w_x(38, 5'd0, 5'd0, 5'd0, 1'b0), 64'd0, 1'b1);
        check("R4 set no record", status, 32'hE0F7_FEFF);
        check("R10 no record keeps cr1", cr, 32'hF6FF_000F);
        issue(w_imm(3'd7, 4'h3, 1'b1), 64'd0, 1'b1);
        check("R6 field 7", status, 32'hE0F7_FEF3);
        check("R10 record clears cr1", cr, 32'hF0FF_000F);
        issue(w_copy(3'd1, 3'd7, 1'b1), 64'd0, 1'b1);
        check("R10 copy ignores record", cr, 32'hF3FF_000F);
        issue(w_x(70, 5'd30, 5'd0, 5'd0, 1'b1), 64'd0, 1'b1);
        check("R4 clear bit 1", status, 32'hE0F7_FEF1);
        check("R10 record keeps SO", cr, 32'hF1FF_000F);
    endtask

    task automatic t_illegal;
        logic [31:0] bad [12];
        issue(w_copy(3'd1, 3'd0, 1'b0), 64'd0, 1'b1);
        check("R8 setup", status, 32'h60F7_FEF1);
        check("R7 setup", cr, 32'hFEFF_000F);
        bad[0]  = {6'd62, w_x(38, 5'd1, 5'd0, 5'd0, 1'b1)[25:0]};
        bad[1]  = w_x(38, 5'd1, 5'd1, 5'd0, 1'b1);
        bad[2]  = w_x(70, 5'd1, 5'd0, 5'd2, 1'b1);
        bad[3]  = w_mask(8'hFF, 1'b1) | 32'h0200_0000;
        bad[4]  = w_mask(8'hFF, 1'b1) | 32'h0001_0000;
        bad[5]  = w_imm(3'd0, 4'hF, 1'b1) | 32'h0000_0800;
        bad[6]  = w_imm(3'd0, 4'hF, 1'b1) | 32'h0001_0000;
        bad[7]  = w_x(64, 5'd5, 5'd0, 5'd0, 1'b0);
        bad[8]  = w_x(64, 5'd4, 5'd2, 5'd0, 1'b0);
        bad[9]  = w_x(64, 5'd4, 5'd0, 5'd1, 1'b0);
        bad[10] = w_x(583, 5'd0, 5'd1, 5'd0, 1'b0);
        bad[11] = w_x(12, 5'd0, 5'd0, 5'd0, 1'b0);
        for (int i = 0; i < 12; i++) begin
            issue(bad[i], 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
            check($sformatf("R11 R3 pulse %0d", i), illegal, 1);
            check($sformatf("R11 status %0d", i), status, 32'h60F7_FEF1);
            check($sformatf("R11 cr %0d", i), cr, 32'hFEFF_000F);
            check($sformatf("R11 rd_val %0d", i), rd_val, 64'hFFF8_0000_60F7_FEFF);
        end
        @(negedge clk);
        check("R11 pulse ends", illegal, 0);
    endtask

    task automatic t_nostrobe;
        issue(w_x(70, 5'd31, 5'd0, 5'd0, 1'b1), 64'd0, 1'b0);
        check("R2 no strobe status", status, 32'h60F7_FEF1);
        check("R2 no strobe cr", cr, 32'hFEFF_000F);
        issue(w_x(583, 5'd0, 5'd0, 5'd0, 1'b0), 64'd0, 1'b0);
        check("R2 no strobe rd_val", rd_val, 64'hFFF8_0000_60F7_FEFF);
        check("R2 no strobe illegal", illegal, 0);
        @(negedge clk);
        instr = w_x(38, 5'd4, 5'd0, 5'd0, 1'b0);
        valid = 1'b1;
        #1;
        check("R2 not before edge", status, 32'h60F7_FEF1);
        @(negedge clk);
        valid = 1'b0;
        check("R2 after edge", status, 32'h68F7_FEF1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_bitops;
        t_masked;
        t_imm;
        t_read;
        t_copy;
        t_record;
        t_illegal;
        t_nostrobe;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule